// File: doc/BRIEF.md
# Byte-Serial Word Exchange Register

This block keeps a single stored word and replaces it through a narrow byte port, handing the previous contents back on the same port width. A transaction opens when the input-valid strobe is seen while the block is idle. That cycle and the three cycles after it each deliver one byte of the replacement word, least-significant byte first. In the next cycle the current stored word is copied into a holding register. In the cycle after that, the assembled word becomes the stored word.

From the cycle after the commit, the block raises its output-valid flag for exactly four cycles. In those cycles it drives the held old word, one byte per cycle, lowest byte first. It then returns to idle. Each exchange therefore takes a fixed ten cycles from the start cycle to the first cycle in which a new start can be accepted. A caller can pipeline exchanges back to back and expect each one to return the word written by the exchange before it.

Top module: `word_exchange_reg`

## Requirements
- R1: After reset, out_valid and out_data are 0, and the stored word is zero, so the first exchange returns 0x00000000.
- R2: Incoming byte i (i = 0..3, counting the start cycle as i = 0) lands in bits [8i+7:8i] of the new word.
- R3: With the start cycle counted as cycle 0, out_valid stays low in cycles 1 to 5 and first rises in cycle 6.
- R4: While out_valid is high, out_data carries the old word as four consecutive bytes: bits [7:0] first, then [15:8], [23:16] and [31:24].
- R5: out_valid stays high for exactly four cycles and is low again in cycle 10.
- R6: Each exchange returns the word that was stored before it and leaves its own new word stored, so the next exchange returns it.
- R7: in_valid has no effect while a transaction is in progress, and in_data has no effect while the block is idle with in_valid low.
- R8: out_data is 0 in every cycle in which out_valid is low.
- R9: A new transaction can start in cycle 10 of the previous one (the first idle cycle), with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Start strobe, sampled only while idle |
| in_data | input | 8 | Byte lane for the incoming word |
| out_valid | output | 1 | High while old-word bytes are presented |
| out_data | output | 8 | Byte lane for the outgoing old word, zero otherwise |

## Verification
The hardest situation to reach from the ports is an in_valid pulse that arrives mid-transaction or exactly in the last output cycle. If that pulse were accepted, it would only show up later as a shifted or corrupted return word. The stimulus holds in_valid high through cycles 1 to 9 of one exchange and puts random bytes on in_data during an idle gap. The exchanges that follow must return exactly the words written before them. Back-to-back exchanges then place a start in cycle 10, so the boundary between an ignored pulse and an accepted one is exercised on both sides.

// File: rtl/xchg_pkg.sv
// Package: shared types for the byte-serial word exchange register.
// Assumes nothing beyond a standard SystemVerilog elaborator.
package xchg_pkg;

    // Transaction phases of the exchange sequencer.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_COLLECT = 3'd1,
        PH_CAPTURE = 3'd2,
        PH_COMMIT  = 3'd3,
        PH_EMIT    = 3'd4
    } phase_e;

endpackage

// File: rtl/xchg_sequencer.sv
// Module: xchg_sequencer
// Walks one exchange through collect, capture, commit and emit phases and
// produces the per-cycle strobes for the datapath. Assumes NUM_BYTES >= 2.
// in_valid is only looked at in the idle phase.
module xchg_sequencer
    import xchg_pkg::*;
#(
    parameter int NUM_BYTES = 4,
    localparam int IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             load_first,
    output logic             load_next,
    output logic             capture,
    output logic             commit,
    output logic             emit,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

    phase_e           phase_q;
    logic [IDX_W-1:0] idx_q;

    // Phase and byte-index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (in_valid) begin
                        phase_q <= PH_COLLECT;
                        idx_q   <= IDX_W'(1);
                    end
                end
                PH_COLLECT: begin
                    if (idx_q == LAST_IDX) begin
                        phase_q <= PH_CAPTURE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                PH_CAPTURE: begin
                    phase_q <= PH_COMMIT;
                end
                PH_COMMIT: begin
                    phase_q <= PH_EMIT;
                    idx_q   <= '0;
                end
                PH_EMIT: begin
                    if (idx_q == LAST_IDX) begin
                        phase_q <= PH_IDLE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    idx_q   <= '0;
                end
            endcase
        end
    end

    // Decode phase into datapath strobes.
    always_comb begin
        load_first = (phase_q == PH_IDLE) && in_valid;
        load_next  = (phase_q == PH_COLLECT);
        capture    = (phase_q == PH_CAPTURE);
        commit     = (phase_q == PH_COMMIT);
        emit       = (phase_q == PH_EMIT);
        idx        = idx_q;
    end

endmodule

// File: rtl/xchg_packer.sv
// Module: xchg_packer
// Assembles the incoming bytes into a word, lowest lane first. On the start
// cycle every lane is cleared except lane 0, which takes the first byte, so
// nothing from an earlier transaction survives. Assumes load_first and
// load_next are never high together.
module xchg_packer #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4,
    localparam int IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int WORD_W   = BYTE_W * NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_first,
    input  logic              load_next,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [WORD_W-1:0] word
);

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;

        // One byte lane of the assembly register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (load_first) begin
                lane_q <= (g == 0) ? byte_in : '0;
            end else if (load_next && (idx == IDX_W'(g))) begin
                lane_q <= byte_in;
            end
        end

        assign word[g*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/xchg_storage.sv
// Module: xchg_storage
// Holds the stored word and the snapshot of its previous value. capture
// copies the stored word into the snapshot; commit overwrites the stored
// word. Assumes the two strobes fall in different cycles.
module xchg_storage #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              commit,
    input  logic [WORD_W-1:0] new_word,
    output logic [WORD_W-1:0] old_word
);

    logic [WORD_W-1:0] store_q;
    logic [WORD_W-1:0] hold_q;

    // Stored word: cleared by reset, replaced on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (commit) begin
            store_q <= new_word;
        end
    end

    // Snapshot of the stored word taken on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (capture) begin
            hold_q <= store_q;
        end
    end

    assign old_word = hold_q;

endmodule

// File: rtl/xchg_unpacker.sv
// Module: xchg_unpacker
// Selects one byte lane of the snapshot word during the emit phase and
// forces the output lane to zero otherwise. Assumes idx < NUM_BYTES.
module xchg_unpacker #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4,
    localparam int IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int WORD_W   = BYTE_W * NUM_BYTES
) (
    input  logic              emit,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] word,
    output logic              valid,
    output logic [BYTE_W-1:0] byte_out
);

    logic [BYTE_W-1:0] lanes [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_split
        assign lanes[g] = word[g*BYTE_W +: BYTE_W];
    end

    // Lane select gated by the emit phase.
    always_comb begin
        valid    = emit;
        byte_out = '0;
        if (emit) begin
            byte_out = lanes[idx];
        end
    end

endmodule

// File: rtl/word_exchange_reg.sv
// Module: word_exchange_reg (top)
// Byte-serial read-and-replace of one stored word. It collects NUM_BYTES
// bytes after a start strobe, snapshots the old word, commits the new one
// and streams the snapshot back. Assumes a single clock domain and a
// synchronous active-low reset; there is no back-pressure on either side.
module word_exchange_reg #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data
);

    localparam int IDX_W  = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
    localparam int WORD_W = BYTE_W * NUM_BYTES;

    logic              load_first;
    logic              load_next;
    logic              capture;
    logic              commit;
    logic              emit;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] asm_word;
    logic [WORD_W-1:0] old_word;

    xchg_sequencer #(
        .NUM_BYTES (NUM_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .load_first (load_first),
        .load_next  (load_next),
        .capture    (capture),
        .commit     (commit),
        .emit       (emit),
        .idx        (idx)
    );

    xchg_packer #(
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (NUM_BYTES)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_first (load_first),
        .load_next  (load_next),
        .idx        (idx),
        .byte_in    (in_data),
        .word       (asm_word)
    );

    xchg_storage #(
        .WORD_W (WORD_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .commit   (commit),
        .new_word (asm_word),
        .old_word (old_word)
    );

    xchg_unpacker #(
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (NUM_BYTES)
    ) u_unpack (
        .emit     (emit),
        .idx      (idx),
        .word     (old_word),
        .valid    (out_valid),
        .byte_out (out_data)
    );

endmodule

// File: rtl/xchg_checker.sv
// Module: xchg_checker
// Port-level timing checks for word_exchange_reg. It tracks the exchange
// window from the ports alone with its own cycle counter. Bound to the top
// module below.
module xchg_checker #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [BYTE_W-1:0] out_data
);

    localparam int FIRST_OUT = NUM_BYTES + 2;
    localparam int END_CYC   = 2 * NUM_BYTES + 2;
    localparam int LAT_W     = $clog2(END_CYC + 1) + 1;
    localparam int RUN_W     = $clog2(NUM_BYTES + 1) + 1;

    logic             busy_q;
    logic [LAT_W-1:0] lat_q;
    logic [RUN_W-1:0] run_q;

    // Cycle position inside the current exchange, seen from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            lat_q  <= '0;
        end else if ((!busy_q || lat_q == LAT_W'(END_CYC)) && in_valid) begin
            busy_q <= 1'b1;
            lat_q  <= LAT_W'(1);
        end else if (busy_q && lat_q == LAT_W'(END_CYC)) begin
            busy_q <= 1'b0;
            lat_q  <= '0;
        end else if (busy_q) begin
            lat_q <= lat_q + LAT_W'(1);
        end
    end

    // Length of the current run of out_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (out_valid) begin
            run_q <= run_q + RUN_W'(1);
        end else begin
            run_q <= '0;
        end
    end

    // R8: the output lane is quiet when not valid.
    a_r8_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0));

    // R1 / R7: nothing is presented outside a transaction.
    a_r7_idle_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !out_valid);

    // R3: quiet during collect, capture and commit.
    a_r3_no_early_output: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && lat_q < LAT_W'(FIRST_OUT)) |-> !out_valid);

    // R3: first output byte appears at the fixed cycle.
    a_r3_first_byte_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && lat_q == LAT_W'(FIRST_OUT)) |-> out_valid);

    // R5: burst ends by the end of the exchange window.
    a_r5_valid_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && lat_q == LAT_W'(END_CYC)) |-> !out_valid);

    // R5: every burst is exactly NUM_BYTES long.
    a_r5_burst_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (run_q == RUN_W'(NUM_BYTES)));

endmodule

bind word_exchange_reg xchg_checker #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES)
) u_xchg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/word_exchange_reg_bench.sv
// Directed bench for word_exchange_reg. Inputs are driven and outputs
// sampled on the falling edge; expected values come from the requirements.
module word_exchange_reg_bench;

    localparam int BW = 8;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [BW-1:0] in_data = '0;
    logic          out_valid;
    logic [BW-1:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #5ns clk = ~clk;

    word_exchange_reg #(.BYTE_W(BW), .NUM_BYTES(NB)) u_word_exchange_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R1: reset state at the ports.
    task automatic t_reset();
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_data  = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        in_data  = '0;
        chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R1 out_data after reset", 32'(out_data), 32'd0);
    endtask

    // One exchange starting at the current falling edge; checks R2-R8.
    task automatic t_exchange(input logic [31:0] new_w, input logic [31:0] exp_old,
                              input bit noise, input string tag);
        in_valid = 1'b1;
        in_data  = new_w[7:0];
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (k <= 5) begin
                chk({"R3 quiet before output ", tag}, 32'(out_valid), 32'd0);
                chk({"R8 zero data while invalid ", tag}, 32'(out_data), 32'd0);
            end else if (k <= 9) begin
                chk({"R4 out_valid during burst ", tag}, 32'(out_valid), 32'd1);
                chk({"R6 old word byte ", tag}, 32'(out_data), 32'(exp_old[8*(k-6) +: 8]));
            end else begin
                chk({"R5 out_valid dropped ", tag}, 32'(out_valid), 32'd0);
                chk({"R8 zero data after burst ", tag}, 32'(out_data), 32'd0);
            end
            if (k <= 3) in_data = new_w[8*k +: 8];
            else        in_data = noise ? 8'($urandom()) : 8'h00;
            in_valid = (k < 10) ? noise : 1'b0;
        end
    endtask

    // R7: idle cycles with junk on in_data and in_valid low.
    task automatic t_idle_junk(input int cycles);
        in_valid = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            in_data = 8'($urandom());
            @(negedge clk);
            chk("R7 no output while idle", 32'(out_valid), 32'd0);
            chk("R8 zero data while idle", 32'(out_data), 32'd0);
        end
        in_data = '0;
    endtask

    initial begin : watchdog
        #2ms;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        // R1: first exchange returns the reset value.
        t_exchange(32'h1234_5678, 32'h0000_0000, 1'b0, "first");
        // R2 / R6: word assembled lowest byte first returns intact.
        t_exchange(32'hDEAD_BEEF, 32'h1234_5678, 1'b0, "second");
        // R7: in_valid held high across the whole exchange is ignored.
        t_exchange(32'h0F1E_2D3C, 32'hDEAD_BEEF, 1'b1, "noisy");
        t_idle_junk(5);
        // R7: idle junk did not start anything; stored word unchanged.
        t_exchange(32'hFFFF_0000, 32'h0F1E_2D3C, 1'b0, "after_gap");
        // R9: back-to-back starts in the first idle cycle.
        t_exchange(32'h8001_7FFE, 32'hFFFF_0000, 1'b0, "b2b_a");
        t_exchange(32'h0000_00FF, 32'h8001_7FFE, 1'b1, "b2b_b");
        t_exchange(32'hC3C3_3C3C, 32'h0000_00FF, 1'b0, "b2b_c");
        // R1: reset mid-life clears the stored word again.
        t_reset();
        t_exchange(32'h5555_AAAA, 32'h0000_0000, 1'b0, "post_reset");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule